// File: doc/BRIEF.md
# Calendar and Scratchpad Register Bank with Write Lock

This block is the storage layer between a serial command engine and a running calendar counter. The engine hands it one byte access at a time: an address on the clock side or on the RAM side, a direction, and write data. The bank holds 24 bytes of scratchpad RAM and eight clock-side registers. Seven of the clock-side registers map onto the calendar fields held by the external counter, and the eighth is a control register whose top bit locks every other register against writes.

Accesses are either single (explicit address) or part of a burst. A burst opens with a start strobe that fixes the side and the direction. An internal pointer then walks from location 0, one step per access, until an end strobe closes the burst. RAM burst writes land byte by byte. Clock burst writes are collected in a staging buffer, and the calendar counter is loaded with all seven fields in a single cycle only when the eighth byte (the control byte) arrives. A burst that ends early is thrown away.

Top module: `rtc_regbank`

## Requirements
- R1: After a synchronous active-low reset, every RAM byte reads 0x00, the lock bit is 0 and `cal_ld_mask` is 0.
- R2: A single RAM write to address 0..23 is stored and read back on `rd_data`. RAM addresses 24..31 read 0x00 and writes to them change nothing.
- R3: Clock addresses 0..6 read calendar field k from `cal_q[8k+7:8k]`. A single write to field k, with the lock clear, sets only `cal_ld_mask[k]` for exactly the following cycle, with the written byte on `cal_ld_data[8k+7:8k]`.
- R4: Clock address 7 is the control register. Bit 7 is the lock and bits 6..0 always read 0. Clock addresses 8..31 read 0x00.
- R5: While the lock bit is 1, writes to RAM and to calendar fields have no effect. A write to the control register still updates the lock.
- R6: A RAM burst write stores each byte at the pointer location (0, 1, 2, ...) in the cycle it arrives, even if the burst ends before 24 bytes. Bytes past location 23 are dropped and do not wrap.
- R7: A clock burst write of eight bytes, with the lock clear, raises all seven `cal_ld_mask` bits for the single cycle after the eighth byte, with bytes 0..6 on their lanes. Bit 7 of the eighth byte becomes the lock. Before the eighth byte no load occurs.
- R8: A clock burst that ends before its eighth byte loads nothing and leaves the lock unchanged. The next burst starts again from location 0.
- R9: During a burst, `rd_data` shows the location at the pointer. The pointer advances by one per access, and locations with no storage read 0x00.
- R10: An end strobe in the same cycle as the eighth clock byte still commits the burst. An access presented in the same cycle as a start strobe is ignored.
- R11: A clock burst whose eighth byte arrives while the lock is 1 loads no calendar field, but its control byte still updates the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Byte access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read (single access or burst start) |
| acc_ram | input | 1 | 1 = RAM side, 0 = clock side (single access or burst start) |
| acc_addr | input | 5 | Address for single accesses |
| acc_wdata | input | 8 | Write byte |
| burst_start | input | 1 | Opens a burst; pointer set to 0 |
| burst_end | input | 1 | Closes or aborts the burst after this cycle's access |
| rd_data | output | 8 | Byte at the addressed location (combinational) |
| cal_q | input | 56 | Live calendar fields from the counter, field k in bits 8k+7:8k |
| cal_ld_mask | output | 7 | Per-field load enable to the counter, one cycle wide |
| cal_ld_data | output | 56 | Load values, field k in bits 8k+7:8k |

## Verification
The sharpest same-cycle case is the end strobe arriving together with the eighth clock-burst byte. The byte must count before the burst closes, so the commit fires. The bench provokes this with a clock burst whose last access carries the end strobe, and also opens a burst with an access on the start cycle. A behavioural reference model, updated on every edge, judges both cases by comparing the load mask and the load lanes on the following cycle and the lock read back afterwards.

// File: rtl/rtc_regbank_pkg.sv
// Shared widths and the effective-access record for the register bank.
package rtc_regbank_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    typedef logic [BYTE_W-1:0] byte_t;

    // One resolved access after burst sequencing.
    typedef struct packed {
        logic              en;
        logic              wr;
        logic              ram;
        logic              burst;
        logic [ADDR_W-1:0] addr;
    } acc_t;
endpackage

// File: rtl/rtc_burst_seq.sv
// Burst sequencer: turns raw accesses into effective accesses.
// Assumes burst_start takes priority over burst_end and over the access
// presented in the same cycle; burst_end closes after that cycle's access.
module rtc_burst_seq
    import rtc_regbank_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic          acc_ram,
    input  logic [AW-1:0] acc_addr,
    input  logic          burst_start,
    input  logic          burst_end,
    output acc_t          eff,
    output logic          stg_clear
);
    localparam logic [AW-1:0] PTR_MAX = {AW{1'b1}};

    logic          act_q;
    logic          ram_q;
    logic          wr_q;
    logic [AW-1:0] ptr_q;

    // Burst mode latch and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            ram_q <= 1'b0;
            wr_q  <= 1'b0;
            ptr_q <= '0;
        end else if (burst_start) begin
            act_q <= 1'b1;
            ram_q <= acc_ram;
            wr_q  <= acc_wr;
            ptr_q <= '0;
        end else begin
            if (act_q && acc_en && ptr_q != PTR_MAX)
                ptr_q <= ptr_q + 1'b1;
            if (burst_end) begin
                act_q <= 1'b0;
                ptr_q <= '0;
            end
        end
    end

    // Resolve the access presented this cycle.
    always_comb begin
        eff.en    = acc_en && !burst_start;
        eff.wr    = act_q ? wr_q  : acc_wr;
        eff.ram   = act_q ? ram_q : acc_ram;
        eff.burst = act_q;
        eff.addr  = act_q ? ptr_q : acc_addr;
    end

    assign stg_clear = burst_start || burst_end;

    // R9: pointer steps by one per burst access
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && acc_en && !burst_start && !burst_end && ptr_q != PTR_MAX)
        |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R6: a new burst always begins at location 0
    a_r6_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (ptr_q == '0 && act_q));
endmodule

// File: rtl/rtc_scratch_ram.sv
// Scratchpad storage of DEPTH bytes. Writes are dropped outside the storage
// range and while the lock is set. Reads beyond the range return zero.
module rtc_scratch_ram
    import rtc_regbank_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_req,
    input  logic [AW-1:0] addr,
    input  byte_t         wdata,
    input  logic          lock,
    output byte_t         rd_byte
);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DEPTH-1:0][BYTE_W-1:0] mem;
    logic                         in_range;

    assign in_range = {1'b0, addr} < LIMIT;

    // Byte store with lock gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we_req && in_range && !lock) begin
            for (int k = 0; k < DEPTH; k++)
                if (addr == AW'(k))
                    mem[k] <= wdata;
        end
    end

    // Read mux with zero fill outside storage.
    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < DEPTH; k++)
            if (addr == AW'(k))
                rd_byte = mem[k];
    end

    // R5: nothing changes in the RAM while locked
    a_r5_lock_freezes_ram: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem));
endmodule

// File: rtl/rtc_clk_stage.sv
// Clock-side write path: lock register, burst staging buffer and the load
// port to the calendar counter. Burst bytes 0..FIELDS-1 are staged. The byte
// at address FIELDS (control) triggers the commit and is applied directly.
module rtc_clk_stage
    import rtc_regbank_pkg::*;
#(
    parameter int FIELDS = 7,
    parameter int AW     = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_req,
    input  logic                     burst,
    input  logic [AW-1:0]            addr,
    input  byte_t                    wdata,
    input  logic                     stg_clear,
    output logic                     lock,
    output logic [FIELDS-1:0]        ld_mask,
    output logic [FIELDS*BYTE_W-1:0] ld_data
);
    localparam logic [AW:0] FLD_LIMIT = (AW+1)'(FIELDS);
    localparam logic [AW:0] CTRL_ADDR = (AW+1)'(FIELDS);

    logic [FIELDS-1:0][BYTE_W-1:0] stg;
    logic [FIELDS-1:0]             stg_vld;
    logic [FIELDS-1:0][BYTE_W-1:0] ld_q;
    logic                          is_field;
    logic                          is_ctrl;
    logic                          commit;

    assign is_field = {1'b0, addr} < FLD_LIMIT;
    assign is_ctrl  = {1'b0, addr} == CTRL_ADDR;
    assign commit   = wr_req && burst && is_ctrl;

    // Staging buffer fill and discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg     <= '0;
            stg_vld <= '0;
        end else if (commit || stg_clear) begin
            stg_vld <= '0;
        end else if (wr_req && burst && is_field) begin
            for (int k = 0; k < FIELDS; k++)
                if (addr == AW'(k)) begin
                    stg[k]     <= wdata;
                    stg_vld[k] <= 1'b1;
                end
        end
    end

    // Lock bit, written by single or burst control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock <= 1'b0;
        else if (wr_req && is_ctrl)
            lock <= wdata[BYTE_W-1];
    end

    // Load port: one-cycle mask, lanes hold their last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_mask <= '0;
            ld_q    <= '0;
        end else begin
            ld_mask <= '0;
            if (commit && !lock && (&stg_vld)) begin
                ld_mask <= '1;
                ld_q    <= stg;
            end else if (wr_req && !burst && is_field && !lock) begin
                for (int k = 0; k < FIELDS; k++)
                    if (addr == AW'(k)) begin
                        ld_mask[k] <= 1'b1;
                        ld_q[k]    <= wdata;
                    end
            end
        end
    end

    assign ld_data = ld_q;

    // R5: no calendar load follows a cycle with the lock set
    a_r5_lock_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
        (|ld_mask) |-> !$past(lock));

    // R3: a load is one field or the whole calendar
    a_r3_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_mask) || (&ld_mask));

    // R7: a full load needs every staged field
    a_r7_full_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        ((&ld_mask) && FIELDS > 1) |-> $past(&stg_vld));

    // R8: an aborted or finished burst leaves no staged bytes behind
    a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
        stg_clear |=> (stg_vld == '0));
endmodule

// File: rtl/rtc_regbank.sv
// Register bank top: scratchpad RAM, calendar-field window with load port,
// control register with write lock, and burst sequencing.
// Assumes the calendar counter applies cal_ld_data lanes where cal_ld_mask
// is set, on the cycle the mask is high.
module rtc_regbank
    import rtc_regbank_pkg::*;
#(
    parameter int RAM_DEPTH  = 24,
    parameter int CAL_FIELDS = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_en,
    input  logic                         acc_wr,
    input  logic                         acc_ram,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic [BYTE_W-1:0]            acc_wdata,
    input  logic                         burst_start,
    input  logic                         burst_end,
    output logic [BYTE_W-1:0]            rd_data,
    input  logic [CAL_FIELDS*BYTE_W-1:0] cal_q,
    output logic [CAL_FIELDS-1:0]        cal_ld_mask,
    output logic [CAL_FIELDS*BYTE_W-1:0] cal_ld_data
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CAL_FIELDS);

    acc_t  eff;
    logic  stg_clear;
    logic  lock;
    byte_t ram_rd;
    byte_t clk_rd;

    rtc_burst_seq #(.AW(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .acc_wr      (acc_wr),
        .acc_ram     (acc_ram),
        .acc_addr    (acc_addr),
        .burst_start (burst_start),
        .burst_end   (burst_end),
        .eff         (eff),
        .stg_clear   (stg_clear)
    );

    rtc_scratch_ram #(.DEPTH(RAM_DEPTH), .AW(ADDR_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_req  (eff.en && eff.wr && eff.ram),
        .addr    (eff.addr),
        .wdata   (acc_wdata),
        .lock    (lock),
        .rd_byte (ram_rd)
    );

    rtc_clk_stage #(.FIELDS(CAL_FIELDS), .AW(ADDR_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (eff.en && eff.wr && !eff.ram),
        .burst     (eff.burst),
        .addr      (eff.addr),
        .wdata     (acc_wdata),
        .stg_clear (stg_clear),
        .lock      (lock),
        .ld_mask   (cal_ld_mask),
        .ld_data   (cal_ld_data)
    );

    // Clock-side read: live calendar fields, control, zero elsewhere.
    always_comb begin
        clk_rd = '0;
        for (int k = 0; k < CAL_FIELDS; k++)
            if (eff.addr == ADDR_W'(k))
                clk_rd = cal_q[k*BYTE_W +: BYTE_W];
        if (eff.addr == CTRL_ADDR)
            clk_rd = {lock, {(BYTE_W-1){1'b0}}};
    end

    assign rd_data = eff.ram ? ram_rd : clk_rd;

    // R4: low control bits always read zero
    a_r4_ctrl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff.ram && eff.addr == CTRL_ADDR) |-> (rd_data[BYTE_W-2:0] == '0));
endmodule

// File: tb/rtc_regbank_bench.sv
`timescale 1ns/100ps
module rtc_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_ram = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        burst_start = 1'b0, burst_end = 1'b0;
    logic [7:0]  rd_data;
    logic [55:0] cal_q = 56'h23_07_14_05_09_30_15;
    logic [6:0]  cal_ld_mask;
    logic [55:0] cal_ld_data;

    int n_chk = 0;
    int n_err = 0;

    // Reference model state
    int m_ram [24];
    bit m_lock;
    bit m_act, m_bram, m_bwr;
    int m_ptr;
    int m_stg [7];
    bit m_vld [7];
    int e_mask;
    int e_data [7];

    always #2.5 clk = ~clk;

    rtc_regbank u_rtc_regbank (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_ram(acc_ram), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .burst_start(burst_start), .burst_end(burst_end), .rd_data(rd_data),
        .cal_q(cal_q), .cal_ld_mask(cal_ld_mask), .cal_ld_data(cal_ld_data)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        foreach (m_ram[i]) m_ram[i] = 0;
        m_lock = 0; m_act = 0; m_bram = 0; m_bwr = 0; m_ptr = 0;
        foreach (m_vld[i]) begin m_vld[i] = 0; m_stg[i] = 0; end
        e_mask = 0;
    endtask

    function automatic int model_rd(input bit ram, input int addr);
        int a = m_act ? m_ptr : addr;
        bit s = m_act ? m_bram : ram;
        if (s) return (a < 24) ? m_ram[a] : 0;
        if (a < 7) return int'(cal_q[a*8 +: 8]);
        if (a == 7) return m_lock ? 8'h80 : 0;
        return 0;
    endfunction

    task automatic model_edge(input bit en, wr, ram, input int addr, wd, input bit bs, be);
        e_mask = 0;
        if (bs) begin
            m_act = 1; m_bram = ram; m_bwr = wr; m_ptr = 0;
            foreach (m_vld[i]) m_vld[i] = 0;
        end else begin
            if (en) begin
                int a = m_act ? m_ptr : addr;
                bit s = m_act ? m_bram : ram;
                bit w = m_act ? m_bwr : wr;
                if (w) begin
                    if (s) begin
                        if (a < 24 && !m_lock) m_ram[a] = wd;
                    end else if (m_act) begin
                        if (a < 7) begin
                            m_stg[a] = wd; m_vld[a] = 1;
                        end else if (a == 7) begin
                            bit all = 1;
                            foreach (m_vld[i]) all &= m_vld[i];
                            if (!m_lock && all) begin
                                e_mask = 'h7F;
                                foreach (m_stg[i]) e_data[i] = m_stg[i];
                            end
                            m_lock = wd[7];
                            foreach (m_vld[i]) m_vld[i] = 0;
                        end
                    end else begin
                        if (a < 7 && !m_lock) begin
                            e_mask = 1 << a; e_data[a] = wd;
                        end else if (a == 7) begin
                            m_lock = wd[7];
                        end
                    end
                end
                if (m_act && m_ptr < 31) m_ptr++;
            end
            if (be) begin
                m_act = 0; m_ptr = 0;
                foreach (m_vld[i]) m_vld[i] = 0;
            end
        end
    endtask

    // One clock of stimulus with model comparison before and after the edge.
    task automatic cyc(input string tag, input bit en, wr, ram, input int addr, wd,
                       input bit bs = 0, input bit be = 0);
        @(negedge clk);
        acc_en = en; acc_wr = wr; acc_ram = ram; acc_addr = 5'(addr);
        acc_wdata = 8'(wd); burst_start = bs; burst_end = be;
        #1;
        chk(tag, "rd_data", int'(rd_data), model_rd(ram, addr));
        @(posedge clk);
        model_edge(en, wr, ram, addr, wd, bs, be);
        #1;
        chk(tag, "cal_ld_mask", int'(cal_ld_mask), e_mask);
        for (int k = 0; k < 7; k++)
            if (e_mask[k]) chk(tag, "cal_ld_data lane", int'(cal_ld_data[k*8 +: 8]), e_data[k]);
    endtask

    task automatic wr1(input string tag, input bit ram, input int addr, wd);
        cyc(tag, 1, 1, ram, addr, wd);
    endtask

    task automatic rd1(input string tag, input bit ram, input int addr);
        cyc(tag, 0, 0, ram, addr, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd1("R1", 1, 0);
        rd1("R1", 1, 23);
        rd1("R1", 0, 7);

        // R2: single RAM writes, edges and empty addresses
        wr1("R2", 1, 0, 'hA5);
        wr1("R2", 1, 23, 'h3C);
        wr1("R2", 1, 24, 'hEE);
        wr1("R2", 1, 31, 'hDD);
        rd1("R2", 1, 0); rd1("R2", 1, 23); rd1("R2", 1, 24); rd1("R2", 1, 31);

        // R3: calendar field reads and single field load
        for (int k = 0; k < 7; k++) rd1("R3", 0, k);
        wr1("R3", 0, 3, 'h12);
        wr1("R3", 0, 0, 'h45);
        cal_q = 56'h99_12_31_07_23_59_58;
        rd1("R3", 0, 6); rd1("R3", 0, 1);

        // R4: control register and empty clock addresses
        wr1("R4", 0, 7, 'h7F);
        rd1("R4", 0, 7);
        rd1("R4", 0, 8); rd1("R4", 0, 31);

        // R5: lock blocks RAM and field writes, not the control itself
        wr1("R5", 0, 7, 'hFF);
        rd1("R5", 0, 7);
        wr1("R5", 1, 0, 'h11);
        rd1("R5", 1, 0);
        wr1("R5", 0, 2, 'h22);
        wr1("R5", 0, 7, 'h00);
        rd1("R5", 0, 7);
        wr1("R5", 1, 0, 'h11);
        rd1("R5", 1, 0);

        // R6: partial RAM burst write, then a long one past the end
        cyc("R6", 0, 1, 1, 0, 0, 1, 0);
        for (int k = 0; k < 5; k++) cyc("R6", 1, 1, 1, 0, 'h50 + k, 0, k == 4);
        for (int k = 0; k < 6; k++) rd1("R6", 1, k);
        cyc("R6", 0, 1, 1, 0, 0, 1, 0);
        for (int k = 0; k < 27; k++) cyc("R6", 1, 1, 1, 0, 'h80 + k, 0, k == 26);
        rd1("R6", 1, 0); rd1("R6", 1, 23);

        // R9: RAM burst read past the end, then clock burst read
        cyc("R9", 0, 0, 1, 0, 0, 1, 0);
        for (int k = 0; k < 26; k++) cyc("R9", 1, 0, 1, 0, 0, 0, k == 25);
        cyc("R9", 0, 0, 0, 0, 0, 1, 0);
        for (int k = 0; k < 10; k++) cyc("R9", 1, 0, 0, 0, 0, 0, k == 9);

        // R7: full clock burst commit
        cyc("R7", 0, 1, 0, 0, 0, 1, 0);
        for (int k = 0; k < 7; k++) cyc("R7", 1, 1, 0, 0, 'h10 + k);
        cyc("R7", 1, 1, 0, 0, 'h00);
        cyc("R7", 0, 0, 0, 0, 0, 0, 1);
        rd1("R7", 0, 7);

        // R8: aborted clock burst, then a fresh complete one
        cyc("R8", 0, 1, 0, 0, 0, 1, 0);
        for (int k = 0; k < 4; k++) cyc("R8", 1, 1, 0, 0, 'h60 + k, 0, k == 3);
        rd1("R8", 0, 7);
        cyc("R8", 0, 1, 0, 0, 0, 1, 0);
        for (int k = 0; k < 8; k++) cyc("R8", 1, 1, 0, 0, (k == 7) ? 0 : 'h70 + k, 0, k == 7);

        // R10: end strobe on the eighth byte; access on the start cycle ignored
        cyc("R10", 1, 1, 0, 0, 'hAA, 1, 0);
        for (int k = 0; k < 8; k++) cyc("R10", 1, 1, 0, 0, (k == 7) ? 'h80 : 'h30 + k, 0, k == 7);
        rd1("R10", 0, 7);
        wr1("R10", 0, 7, 'h00);
        cyc("R10", 1, 1, 1, 5, 'h77, 1, 0);
        cyc("R10", 1, 1, 1, 0, 'h99, 0, 1);
        rd1("R10", 1, 0); rd1("R10", 1, 5);

        // R11: locked clock burst loads nothing but clears the lock
        wr1("R11", 0, 7, 'h80);
        cyc("R11", 0, 1, 0, 0, 0, 1, 0);
        for (int k = 0; k < 8; k++) cyc("R11", 1, 1, 0, 0, (k == 7) ? 0 : 'h40 + k, 0, k == 7);
        rd1("R11", 0, 7);
        wr1("R11", 0, 4, 'h08);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule